// File: doc/BRIEF.md
# I2C Register Target with Split Read Transactions

This block is a serial-bus target that gives an external master access to a small internal register file. It answers only to one fixed 7-bit device address, 1000100 in binary. The address byte is therefore 0x88 for a write and 0x89 for a read. Both directions support single-byte and multi-byte transfers. The system clock oversamples the bus lines through a two-stage synchroniser, and edge logic finds the SCL edges and the start and stop conditions. A state machine then receives or sends bytes. The block pulls SDA low through an open-drain enable and never drives it high.

A write transaction carries the device address, then a register pointer, then any number of data bytes. There is no repeated start. To read a register, the master first writes the pointer and ends that transaction with a stop. It then opens a new transaction with the read address. The block keeps the pointer across the stop and returns bytes from that pointer.

The state machine has ten named states. ST_IDLE waits for a start. ST_ADDR shifts in the address byte, then goes to ST_ADDR_ACK on a match or to ST_WAIT_STOP on a mismatch. ST_ADDR_ACK drives the ACK and then goes to ST_PTR for a write or ST_RDATA for a read. ST_PTR loads the pointer and goes to ST_PTR_ACK, which leads to ST_WDATA. ST_WDATA strobes each byte into the register file and goes to ST_WDATA_ACK, which returns to ST_WDATA. ST_RDATA shifts a byte out and goes to ST_RACK. ST_RACK goes back to ST_RDATA when the master ACKs and to ST_WAIT_STOP when it NACKs. ST_WAIT_STOP ignores the bus. A stop takes every state to ST_IDLE. A start in any state other than ST_IDLE goes to ST_WAIT_STOP.

Top module: `i2c_reg_target`

## Requirements
- R1: A start seen in idle, followed by the address byte 0x88 or 0x89 (7 address bits MSB first, R/W in bit 0, 1 = read), is acknowledged: sda_oe is 1 during the ninth SCL clock.
- R2: An address byte with any other 7-bit address is not acknowledged. SDA stays released and no register write happens until the next stop.
- R3: In a write, the byte after the address byte loads the register pointer, which appears on rf_addr, and is acknowledged.
- R4: Each further write byte is acknowledged and written with a one-cycle rf_wr_en pulse at the current pointer. The pointer then advances by one.
- R5: A read returns the register at the pointer MSB first. sda_oe begins driving low only while SCL is low.
- R6: In a read, an ACK from the master (SDA low in the ninth clock) starts the next byte from the incremented pointer. A NACK releases SDA for the rest of the transaction.
- R7: The pointer keeps its value across a stop, so a later read starts where the last write or read left it.
- R8: A start that arrives while a transaction is open aborts it. SDA is released and the bus is ignored, including writes, until a stop. After that stop a new transaction works.
- R9: After reset sda_oe and rf_wr_en are 0 and the pointer is 0.
- R10: A stop in the middle of a data byte discards the partial byte without any register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rf_addr | output | AW | Register pointer, used as the register-file address |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wr_data | output | 8 | Write data |
| rf_rd_data | input | 8 | Read data for rf_addr, combinational |

## Verification
Assertions check four things on every cycle. The block may start pulling SDA only while the synchronised SCL is low. The write strobe is a single cycle and advances the pointer. A start during an open transaction enters the wait-for-stop state, which is left only on a stop. A stop always returns the machine to idle. Only the bench scenarios can show the rest: which bytes actually come back on a read, ACK versus NACK on a given address, the pointer surviving a stop between the write and the read, and a cut-off byte leaving the register file untouched.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT_STOP
    } xfer_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s
);
    logic [STAGES-1:0] chain;

    // Bus lines idle high, so reset to 1 avoids false edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_i};
    end

    assign line_s = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000100,
    parameter int         AW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rf_rd_data,
    output logic              sda_oe,
    output logic [AW-1:0]     rf_addr,
    output logic              rf_wr_en,
    output logic [BYTE_W-1:0] rf_wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    xfer_state_t       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [AW-1:0]     ptr;
    logic              rw;
    logic              m_ack;
    logic              rx_done;

    assign rx_done = scl_fall && (cnt == LAST_BIT);
    assign rf_addr = ptr;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            tx         <= '0;
            ptr        <= '0;
            rw         <= 1'b0;
            m_ack      <= 1'b0;
            rf_wr_en   <= 1'b0;
            rf_wr_data <= '0;
        end else begin
            rf_wr_en <= 1'b0;
            if (rf_wr_en) ptr <= ptr + 1'b1;
            if (stop_det) begin
                state <= ST_IDLE;
            end else if (start_det) begin
                state <= (state == ST_IDLE) ? ST_ADDR : ST_WAIT_STOP;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT_STOP: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (rx_done) begin
                            cnt <= '0;
                            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                                state <= ST_ADDR_ACK;
                                rw    <= sh[0];
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_PTR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (rx_done) begin
                            cnt   <= '0;
                            ptr   <= AW'(sh);
                            state <= ST_PTR_ACK;
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (rx_done) begin
                            cnt        <= '0;
                            rf_wr_en   <= 1'b1;
                            rf_wr_data <= sh;
                            state      <= ST_WDATA_ACK;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                state <= ST_RDATA;
                                tx    <= rf_rd_data;
                                ptr   <= ptr + 1'b1;
                            end else begin
                                state <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            tx <= {tx[BYTE_W-2:0], 1'b0};
                            if (cnt == LAST_BIT - 1'b1) begin
                                cnt   <= '0;
                                state <= ST_RACK;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                state <= ST_RDATA;
                                tx    <= rf_rd_data;
                                ptr   <= ptr + 1'b1;
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx[BYTE_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assert_pull_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    assert_wr_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> (rf_addr == AW'($past(rf_addr) + 1'b1)));

    assert_abort_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det && state != ST_IDLE) |=> state == ST_WAIT_STOP);

    assert_hold_until_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STOP && !stop_det) |=> state == ST_WAIT_STOP);

    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1000100,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [AW-1:0]     rf_addr,
    output logic              rf_wr_en,
    output logic [BYTE_W-1:0] rf_wr_data,
    input  logic [BYTE_W-1:0] rf_rd_data
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] sync_lines;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_s (sync_lines[g])
        );
    end

    i2c_cond_detect u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (sync_lines[0]),
        .sda_s     (sync_lines[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (sync_lines[0]),
        .sda_s      (sync_lines[1]),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .rf_rd_data (rf_rd_data),
        .sda_oe     (sda_oe),
        .rf_addr    (rf_addr),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_data (rf_wr_data)
    );
endmodule

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, rf_wr_en;
    logic [7:0] rf_addr, rf_wr_data, rf_rd_data;
    wire sda_line = sda_m & ~sda_oe;

    logic [7:0] mem [256];
    int wr_count = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    i2c_reg_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_wr_en(rf_wr_en),
        .rf_wr_data(rf_wr_data), .rf_rd_data(rf_rd_data)
    );

    assign rf_rd_data = mem[rf_addr];

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 7 + 3);
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);

    always @(posedge clk) if (rf_wr_en) begin
        mem[rf_addr] <= rf_wr_data;
        wr_count <= wr_count + 1;
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
        acked = (sda_line == 1'b0);
        w(Q); scl = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); scl = 1'b1; w(Q); b[i] = sda_line; w(Q); scl = 1'b0; w(Q);
        end
        sda_m = ~give_ack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q); sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bit a;
        bus_start;
        send_byte(8'h88, a); chk("R1", a, 1, "write address ack");
        send_byte(p, a);     chk("R3", a, 1, "pointer ack");
        bus_stop;
    endtask

    task automatic t_reset;
        chk("R9", sda_oe, 0, "sda_oe after reset");
        chk("R9", rf_wr_en, 0, "rf_wr_en after reset");
        chk("R9", rf_addr, 0, "pointer after reset");
    endtask

    task automatic t_write_single;
        bit a;
        bus_start;
        send_byte(8'h88, a); chk("R1", a, 1, "address 0x88 ack");
        send_byte(8'h10, a); chk("R3", a, 1, "pointer ack");
        chk("R3", rf_addr, 8'h10, "pointer loaded");
        send_byte(8'hA5, a); chk("R4", a, 1, "data ack");
        bus_stop;
        chk("R4", mem[8'h10], 8'hA5, "single write data");
        chk("R7", rf_addr, 8'h11, "pointer after stop");
    endtask

    task automatic t_write_multi;
        bit a;
        int c0 = wr_count;
        bus_start;
        send_byte(8'h88, a);
        send_byte(8'h20, a);
        send_byte(8'h3C, a); chk("R4", a, 1, "multi data ack 0");
        send_byte(8'hC3, a); chk("R4", a, 1, "multi data ack 1");
        send_byte(8'h5A, a); chk("R4", a, 1, "multi data ack 2");
        bus_stop;
        chk("R4", mem[8'h20], 8'h3C, "multi write byte 0");
        chk("R4", mem[8'h21], 8'hC3, "multi write byte 1");
        chk("R4", mem[8'h22], 8'h5A, "multi write byte 2");
        chk("R4", wr_count - c0, 3, "write strobe count");
        chk("R4", rf_addr, 8'h23, "pointer after three writes");
    endtask

    task automatic t_read_single;
        bit a;
        logic [7:0] d;
        set_ptr(8'h10);
        bus_start;
        send_byte(8'h89, a); chk("R1", a, 1, "address 0x89 ack");
        recv_byte(1'b0, d);  chk("R5", d, 8'hA5, "single read data");
        chk("R6", sda_oe, 0, "released after nack");
        bus_stop;
    endtask

    task automatic t_read_multi;
        bit a;
        logic [7:0] d;
        set_ptr(8'h20);
        bus_start;
        send_byte(8'h89, a);
        recv_byte(1'b1, d); chk("R6", d, 8'h3C, "burst byte 0");
        recv_byte(1'b1, d); chk("R6", d, 8'hC3, "burst byte 1");
        recv_byte(1'b0, d); chk("R6", d, 8'h5A, "burst byte 2");
        begin
            int low = 0;
            for (int i = 0; i < 9; i++) begin
                w(Q); scl = 1'b1; w(Q); if (!sda_line) low++; w(Q); scl = 1'b0; w(Q);
            end
            chk("R6", low, 0, "no drive after nack");
        end
        bus_stop;
    endtask

    task automatic t_read_kept_ptr;
        bit a;
        logic [7:0] d;
        chk("R7", rf_addr, 8'h23, "pointer kept after stop");
        bus_start;
        send_byte(8'h89, a);
        recv_byte(1'b0, d); chk("R7", d, init_val(8'h23), "read from kept pointer");
        bus_stop;
    endtask

    task automatic t_wrong_addr;
        bit a;
        int c0 = wr_count;
        bus_start;
        send_byte(8'h90, a); chk("R2", a, 0, "foreign address nack");
        send_byte(8'h10, a); chk("R2", a, 0, "ignored byte nack");
        send_byte(8'hFF, a);
        bus_stop;
        chk("R2", wr_count - c0, 0, "no write on foreign address");
        chk("R2", mem[8'h10], 8'hA5, "register untouched");
    endtask

    task automatic t_abort;
        bit a;
        logic [7:0] d;
        int c0 = wr_count;
        bus_start;
        send_byte(8'h88, a);
        send_byte(8'h40, a);
        bus_start;
        send_byte(8'h88, a); chk("R8", a, 0, "no ack after repeated start");
        send_byte(8'h77, a);
        send_byte(8'h66, a);
        bus_stop;
        chk("R8", wr_count - c0, 0, "no write while ignoring");
        chk("R8", mem[8'h40], init_val(8'h40), "register untouched on abort");
        bus_start;
        send_byte(8'h89, a); chk("R8", a, 1, "new transaction after stop");
        recv_byte(1'b0, d);  chk("R8", d, init_val(8'h40), "read after abort");
        bus_stop;
    endtask

    task automatic t_partial_stop;
        bit a;
        int c0 = wr_count;
        bus_start;
        send_byte(8'h88, a);
        send_byte(8'h30, a);
        send_bits(8'hE1, 4);
        bus_stop;
        chk("R10", wr_count - c0, 0, "no write on partial byte");
        chk("R10", mem[8'h30], init_val(8'h30), "register untouched");
        chk("R10", sda_oe, 0, "released after stop");
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        w(3);
        t_reset;
        t_write_single;
        t_write_multi;
        t_read_single;
        t_read_multi;
        set_ptr(8'h23);
        t_read_kept_ptr;
        t_wrong_addr;
        t_abort;
        t_partial_stop;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule